// File: doc/BRIEF.md
# Instruction-Cycle Timer and Watchdog with Shared Prescaler

This block holds an 8-bit up-counting timer and a down-counting watchdog. Both advance on a per-instruction-cycle tick. A single programmable prescaler sits between the tick and one of the two counters, and a configuration byte chooses which one. The counter that does not own the prescaler sees every tick directly. When the prescaler is steered to the timer, its division ratio is twice the selected power of two.

Software writes to the timer register and clear-watchdog instructions restart the prescaler. The block sets a sticky overflow flag when the timer wraps. It raises an interrupt request when both the global enable and the timer enable are set. When the watchdog runs out, it drops a status time-out flag.

Top module: `tw_timer_wdt`

Configuration byte fields: bits 2:0 select the exponent n. Bit 3 is the prescaler owner (1 means watchdog, 0 means timer). Bit 5 halts the timer.

## Requirements
- R1: After reset `tmr_val` is 0, `ovf_flag`, `irq` and `wdt_timeout` are 0, `to_n_flag` is 1, and the prescaler is primed so that the first enabled tick counts as an expiry.
- R2: With config bit 3 = 0 and bit 5 = 0, the timer increments once every 2^(n+1) ticks, where n = config bits 2:0.
- R3: With config bit 3 = 1, the timer increments on every tick (if bit 5 = 0), and the watchdog decrements once every 2^n ticks.
- R4: With config bit 3 = 0, the watchdog decrements on every tick.
- R5: With config bit 5 = 1, the timer holds its value. While the prescaler is owned by the timer, the prescaler is frozen as well.
- R6: A timer increment from 0xFF to 0x00 sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed. A wrap in the same cycle as `ovf_clr` leaves the flag set.
- R7: `irq` equals `ovf_flag` AND `gie` AND `tie`.
- R8: The watchdog reloads to `WDT_LOAD`. A decrement that reaches zero produces a one-cycle `wdt_timeout` pulse in the next cycle, clears `to_n_flag`, and reloads the count. Only reset sets `to_n_flag` again, apart from R9.
- R9: `clr_wdt` sets `to_n_flag`. When config bit 3 = 1, it also reloads the prescaler to 2^n and the watchdog to `WDT_LOAD`. When bit 3 = 0, the watchdog count is left untouched.
- R10: `tmr_wr` loads `tmr_wdata` into the timer, overriding an increment in that cycle. When config bit 3 = 0, it also reloads the prescaler so that the next timer increment comes 2^(n+1)-1 ticks later.
- R11: In a cycle with `cyc_tick` low, neither counter nor the prescaler advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One instruction cycle elapsed |
| cfg_byte | input | 8 | Configuration byte (n, owner, timer halt) |
| tmr_wr | input | 1 | Timer register write strobe |
| tmr_wdata | input | 8 | Timer write data |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| ovf_clr | input | 1 | Clears the overflow flag |
| gie | input | 1 | Global interrupt enable |
| tie | input | 1 | Timer interrupt enable |
| tmr_val | output | 8 | Timer value |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| irq | output | 1 | Interrupt request |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |
| to_n_flag | output | 1 | Status time-out flag, low after a time-out |

## Verification
A wrong prescaler count shows up at `tmr_val` within one division period: an increment arrives early or late relative to the expected 2^(n+1) spacing. A wrong watchdog count only becomes visible when `wdt_timeout` and `to_n_flag` move, up to a full reload period later. For this reason the bench uses a short reload value and compares every cycle. Mis-steering the prescaler changes the timer's rate immediately, because the timer then counts every tick or every 2^(n+1) ticks, which is a gross difference.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int SEL_W    = 3;
  localparam int PCNT_W   = (1 << SEL_W) + 1;
  localparam int CFG_SEL  = 0;
  localparam int CFG_OWN  = 3;
  localparam int CFG_HALT = 5;

  // Division ratio: 2^n for the watchdog, 2^(n+1) for the timer.
  function automatic logic [PCNT_W-1:0] ps_ratio(input logic [SEL_W-1:0] sel,
                                                 input logic to_wdt);
    logic [PCNT_W-1:0] r;
    int sh;
    sh = int'(sel) + (to_wdt ? 0 : 1);
    r = '0;
    r[sh] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/tw_prescaler.sv
module tw_prescaler
  import tw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  input  logic             to_wdt,
  input  logic             load_wr,
  input  logic             load_clr,
  output logic             expire
);
  logic [PCNT_W-1:0] cnt;
  logic [PCNT_W-1:0] ratio;

  assign ratio  = ps_ratio(sel, to_wdt);
  assign expire = step && !load_wr && !load_clr && (cnt == PCNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= PCNT_W'(1);
    else if (load_wr)  cnt <= ratio - PCNT_W'(1);
    else if (load_clr) cnt <= ratio;
    else if (step)     cnt <= (cnt == PCNT_W'(1)) ? ratio : cnt - PCNT_W'(1);
  end

  // R11
  prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !load_wr && !load_clr |=> $stable(cnt));
endmodule

// File: rtl/tw_timer8.sv
module tw_timer8 #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          wr,
  input  logic [TW-1:0] wdata,
  input  logic          ovf_clr,
  output logic [TW-1:0] q,
  output logic          ovf,
  output logic          wrap
);
  assign wrap = inc && !wr && (q == {TW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      ovf <= 1'b0;
    end else begin
      if (wr)       q <= wdata;
      else if (inc) q <= q + TW'(1);
      if (wrap)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  // R6
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf && q == '0);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
  // R10
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(wdata));
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int LOAD = 18000,
  localparam int W   = $clog2(LOAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dec,
  input  logic reload,
  input  logic clr_wdt,
  output logic timeout,
  output logic to_n
);
  logic [W-1:0] cnt;
  logic         expire;

  assign expire = dec && !reload && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= W'(LOAD);
      timeout <= 1'b0;
      to_n    <= 1'b1;
    end else begin
      timeout <= expire;
      if (reload || expire) cnt <= W'(LOAD);
      else if (dec)         cnt <= cnt - W'(1);
      if (clr_wdt)     to_n <= 1'b1;
      else if (expire) to_n <= 1'b0;
    end
  end

  // R8
  expire_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !clr_wdt |=> !to_n && timeout);
  // R9
  clear_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> to_n);
  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
endmodule

// File: rtl/tw_timer_wdt.sv
module tw_timer_wdt
  import tw_pkg::*;
#(
  parameter int WDT_LOAD = 18000,
  parameter int TW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_tick,
  input  logic [7:0]    cfg_byte,
  input  logic          tmr_wr,
  input  logic [TW-1:0] tmr_wdata,
  input  logic          clr_wdt,
  input  logic          ovf_clr,
  input  logic          gie,
  input  logic          tie,
  output logic [TW-1:0] tmr_val,
  output logic          ovf_flag,
  output logic          irq,
  output logic          wdt_timeout,
  output logic          to_n_flag
);
  logic own_wdt, halt, ps_step, ps_expire, tmr_inc, wdt_dec, wrap_evt;

  assign own_wdt = cfg_byte[CFG_OWN];
  assign halt    = cfg_byte[CFG_HALT];
  assign ps_step = cyc_tick && (own_wdt || !halt);
  assign tmr_inc = cyc_tick && !halt && (own_wdt || ps_expire);
  assign wdt_dec = cyc_tick && (!own_wdt || ps_expire);
  assign irq     = ovf_flag && gie && tie;

  tw_prescaler i_ps (
    .clk(clk), .rst_n(rst_n), .step(ps_step),
    .sel(cfg_byte[CFG_SEL +: SEL_W]), .to_wdt(own_wdt),
    .load_wr(tmr_wr && !own_wdt), .load_clr(clr_wdt && own_wdt),
    .expire(ps_expire)
  );

  tw_timer8 #(.TW(TW)) i_tmr (
    .clk(clk), .rst_n(rst_n), .inc(tmr_inc), .wr(tmr_wr), .wdata(tmr_wdata),
    .ovf_clr(ovf_clr), .q(tmr_val), .ovf(ovf_flag), .wrap(wrap_evt)
  );

  tw_watchdog #(.LOAD(WDT_LOAD)) i_wdt (
    .clk(clk), .rst_n(rst_n), .dec(wdt_dec), .reload(clr_wdt && own_wdt),
    .clr_wdt(clr_wdt), .timeout(wdt_timeout), .to_n(to_n_flag)
  );

  // R3
  direct_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_wdt && cyc_tick && !halt && !tmr_wr |=> tmr_val == $past(tmr_val) + TW'(1));
  // R11
  idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_tick && !tmr_wr |=> $stable(tmr_val));
  // R11
  idle_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_tick |=> !wdt_timeout);
  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !tmr_wr |=> $stable(tmr_val));
endmodule

// File: tb/test_tw_timer_wdt.sv
module test_tw_timer_wdt;
  localparam int LOAD = 300;
  logic clk = 0, rst_n = 0;
  logic cyc_tick = 0, tmr_wr = 0, clr_wdt = 0, ovf_clr = 0, gie = 0, tie = 0;
  logic [7:0] cfg_byte = 8'hFF, tmr_wdata = 0;
  logic [7:0] tmr_val;
  logic ovf_flag, irq, wdt_timeout, to_n_flag;

  int total = 0, bad = 0;
  string phase = "R1";
  bit done = 0;

  int m_pc, m_wdt;
  logic [7:0] m_tmr;
  logic m_ovf, m_to_n, m_pulse;

  always #4 clk = ~clk;

  tw_timer_wdt #(.WDT_LOAD(LOAD)) i_tw_timer_wdt (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .cfg_byte(cfg_byte),
    .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .clr_wdt(clr_wdt), .ovf_clr(ovf_clr),
    .gie(gie), .tie(tie), .tmr_val(tmr_val), .ovf_flag(ovf_flag), .irq(irq),
    .wdt_timeout(wdt_timeout), .to_n_flag(to_n_flag)
  );

  function automatic int ratio_of(input logic [7:0] c);
    return c[3] ? (1 << c[2:0]) : (2 << c[2:0]);
  endfunction

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pc = 1; m_wdt = LOAD; m_tmr = 0; m_ovf = 0; m_to_n = 1; m_pulse = 0;
  endtask

  task automatic model_step();
    int r;
    bit own, halt, pexp, inc, wdec, wrap, rl;
    own = cfg_byte[3]; halt = cfg_byte[5]; r = ratio_of(cfg_byte);
    pexp = 0;
    if (tmr_wr && !own) m_pc = r - 1;
    else if (clr_wdt && own) m_pc = r;
    else if (cyc_tick && (own || !halt)) begin
      if (m_pc <= 1) begin m_pc = r; pexp = 1; end
      else m_pc--;
    end
    inc  = cyc_tick && !halt && (own || pexp);
    wrap = inc && !tmr_wr && m_tmr == 8'hFF;
    if (tmr_wr) m_tmr = tmr_wdata;
    else if (inc) m_tmr = m_tmr + 8'd1;
    if (wrap) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
    wdec = cyc_tick && (!own || pexp);
    rl = clr_wdt && own;
    m_pulse = 0;
    if (rl) m_wdt = LOAD;
    else if (wdec) begin
      if (m_wdt == 1) begin m_wdt = LOAD; m_pulse = 1; end
      else m_wdt--;
    end
    if (clr_wdt) m_to_n = 1; else if (m_pulse) m_to_n = 0;
  endtask

  task automatic compare();
    check("tmr_val", tmr_val, m_tmr);
    check("ovf_flag", ovf_flag, m_ovf);
    check("irq", irq, m_ovf && gie && tie);
    check("to_n_flag", to_n_flag, m_to_n);
    check("wdt_timeout", wdt_timeout, m_pulse);
  endtask

  task automatic cyc(input logic tk, input logic wr, input logic [7:0] wd,
                     input logic cw, input logic oc);
    cyc_tick = tk; tmr_wr = wr; tmr_wdata = wd; clr_wdt = cw; ovf_clr = oc;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0421));
    @(negedge clk);
    do_reset();
    phase = "R1"; compare();

    // R2: owner timer, n=1 -> one increment per 4 ticks
    phase = "R2"; cfg_byte = 8'h01; run_ticks(40);
    check("R2 tmr after 40 ticks", tmr_val, 10);
    // R11: no tick, nothing moves
    phase = "R11"; for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 0);
    check("R11 tmr frozen", tmr_val, 10);
    // R10: write with timer-owned prescaler, n=2 -> next inc after 7 ticks
    phase = "R10"; cfg_byte = 8'h02; cyc(1, 1, 8'h50, 0, 0); run_ticks(6);
    check("R10 before inc", tmr_val, 8'h50);
    run_ticks(1); check("R10 at inc", tmr_val, 8'h51);
    // R5: halt
    phase = "R5"; cfg_byte = 8'h20; run_ticks(30); check("R5 held", tmr_val, 8'h51);
    // R3 and R6: owner watchdog, direct count through wrap
    phase = "R6"; cfg_byte = 8'h08; cyc(1, 1, 8'hFD, 0, 0); run_ticks(3);
    check("R6 wrapped", tmr_val, 0); check("R6 flag", ovf_flag, 1);
    run_ticks(5); check("R6 sticky", ovf_flag, 1);
    // R7
    phase = "R7"; gie = 1; tie = 0; run_ticks(2); check("R7 tie off", irq, 0);
    tie = 1; run_ticks(1); check("R7 both on", irq, 1);
    cyc(1, 0, 0, 0, 1); check("R6 cleared", ovf_flag, 0); check("R7 after clr", irq, 0);
    // R6: clear coincident with wrap
    phase = "R6"; cyc(1, 1, 8'hFE, 0, 0); cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 1);
    check("R6 set beats clear", ovf_flag, 1);
    // R3: watchdog prescaled by 2 with owner watchdog
    phase = "R3"; cfg_byte = 8'h09; run_ticks(200);
    // R9: clear with watchdog owner
    phase = "R9"; cyc(1, 0, 0, 1, 0); check("R9 flag", to_n_flag, 1);
    // R4 and R8: owner timer, watchdog every tick -> time-out within LOAD ticks
    phase = "R8"; cfg_byte = 8'h07; run_ticks(LOAD + 5);
    check("R8 flag dropped", to_n_flag, 0);
    phase = "R9"; cyc(1, 0, 0, 1, 0); check("R9 restore", to_n_flag, 1);
    phase = "R4"; run_ticks(LOAD); 

    phase = "R2";
    for (int seg = 0; seg < 16; seg++) begin
      cfg_byte = 8'($urandom) & 8'h2F;
      if ($urandom_range(0, 3) == 0) cfg_byte[5] = 1'b0;
      gie = 1'($urandom); tie = 1'($urandom);
      phase = cfg_byte[3] ? "R3" : "R4";
      for (int k = 0; k < 500; k++)
        cyc($urandom_range(0, 9) < 8, $urandom_range(0, 99) < 2, 8'($urandom),
            $urandom_range(0, 149) == 0, $urandom_range(0, 39) == 0);
    end

    do_reset();
    phase = "R1"; compare();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule